// File: doc/BRIEF.md
# Stereo Stepped Attenuator with Soft Mute

This block scales a stereo stream of 20-bit signed samples by a gain chosen from a 6-bit attenuation code. It sits in a playback path after the serial input stage and before the interpolation filter. Each strobe on `in_valid` presents one left/right pair. Two clock edges later, a matching pulse on `out_valid` carries the scaled pair. The attenuation code selects 0 dB down to -60 dB in 1 dB steps, and the top codes silence the output.

A separate mute request does not cut the signal at once. A four-state controller (RUN, FADE_OUT, MUTED, FADE_IN) moves a ramp level between full scale and zero by one step per accepted sample, and the ramp multiplies the volume gain. The transitions are:

- RUN goes to FADE_OUT on a muted sample.
- FADE_OUT goes to MUTED when the ramp reaches zero, or to FADE_IN when mute is released.
- MUTED goes to FADE_IN on release.
- FADE_IN goes to RUN when the ramp is full again, or back to FADE_OUT when mute is requested again.

If the ramp reaches full or zero within one step, the controller lands straight in RUN or MUTED.

Top module: `stereo_gain_stage`

## Requirements
- R1: After reset, `out_valid` is 0, both outputs are 0 and the ramp level is full (32), so an unmuted first sample is not faded.
- R2: A pair captured at clock edge N appears on the outputs after edge N+1, with `out_valid` high for exactly that one cycle. `out_valid` is low in every cycle that does not follow a strobe by two edges.
- R3: Codes 0 and 1 both give unity gain: with the ramp full, the output equals the input bit for bit, including -524288 and +524287.
- R4: Code c from 2 to 61 attenuates by c-1 dB. Its gain is G(c-1) in units of 1/65536, where G(0)=65536 and G(k)=floor((G(k-1)*58409+32768)/65536).
- R5: Codes 62 and 63 give a gain of zero, so both outputs are 0.
- R6: Each output is floor((x*g+32768)/65536), clamped to the signed 20-bit range. Here g is the effective gain of the sample.
- R7: The ramp level r runs from 0 to 32, and the effective gain is floor(G*r/32). Each accepted sample uses the current r. Then r moves one step toward 0 if mute was requested with that sample, or toward 32 if it was not.
- R8: `vol_code` and `mute_req` are sampled only on strobe cycles. Changes between strobes alter neither the held outputs nor the ramp.
- R9: Both channels of a pair use the same gain, so equal inputs give equal outputs.
- R10: The ramp controller holds RUN only at full level and MUTED only at zero. It steps by at most one level per strobe and never moves without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe for one input sample pair |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| vol_code | input | 6 | Attenuation code, sampled with the strobe |
| mute_req | input | 1 | Soft mute request, sampled with the strobe |
| out_valid | output | 1 | Strobe for one processed pair |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |

## Verification
Some properties are checked on every cycle: the two-edge relation between the input and output strobes, and held outputs between strobes. The same applies to the ramp controller: a bounded ramp that moves at most one level per strobe and is frozen without one, and agreement between the controller state and the ramp ends. A zero effective gain always yields silent outputs. The exact gain curve, the rounding, the bit-exact unity codes and the shape of the fade over many samples are shown only by the bench scenarios. These compare each output pair with a model of the gain recurrence and ramp, under directed corner values and seeded random traffic.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_FADE_OUT,
        ST_MUTED,
        ST_FADE_IN
    } mute_state_e;

    // gains are unsigned fractions with this many fraction bits (unity = 1 << GAIN_FRAC)
    localparam int GAIN_FRAC  = 16;
    // one decibel of attenuation, expressed in 1/65536 units
    localparam longint DB_STEP = 58409;

    // gain after a given number of 1 dB attenuation steps, rounded at each step
    function automatic longint att_gain(input int steps);
        longint g;
        g = longint'(1) << GAIN_FRAC;
        for (int i = 0; i < steps; i++) begin
            g = (g * DB_STEP + (longint'(1) << (GAIN_FRAC - 1))) >> GAIN_FRAC;
        end
        return g;
    endfunction

endpackage

// File: rtl/sg_gain_rom.sv
module sg_gain_rom #(
    parameter int CODE_W       = 6,
    parameter int MAX_ATTEN_DB = 60,
    parameter int GAIN_W       = 17
) (
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);
    localparam int N_CODES = 1 << CODE_W;

    logic [GAIN_W-1:0] entry [N_CODES];

    for (genvar c = 0; c < N_CODES; c++) begin : g_entry
        localparam int STEPS = (c == 0) ? 0 : c - 1;
        localparam logic [GAIN_W-1:0] VAL =
            (STEPS > MAX_ATTEN_DB) ? '0 : GAIN_W'(sg_pkg::att_gain(STEPS));
        assign entry[c] = VAL;
    end

    assign gain = entry[code];

endmodule

// File: rtl/sg_ramp_fsm.sv
module sg_ramp_fsm #(
    parameter int RAMP_LEN = 32,
    localparam int RAMP_W  = $clog2(RAMP_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                mute_req,
    output logic [RAMP_W-1:0]   ramp_lvl,
    output sg_pkg::mute_state_e mute_state
);
    import sg_pkg::*;

    localparam logic [RAMP_W-1:0] FULL = RAMP_W'(RAMP_LEN);

    mute_state_e       state_q, state_n;
    logic [RAMP_W-1:0] ramp_q, ramp_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            ramp_q  <= FULL;
        end else begin
            state_q <= state_n;
            ramp_q  <= ramp_n;
        end
    end

    // next state and ramp level
    always_comb begin
        state_n = state_q;
        ramp_n  = ramp_q;
        if (step) begin
            unique case (state_q)
                ST_RUN: begin
                    if (mute_req) begin
                        ramp_n  = ramp_q - 1'b1;
                        state_n = (ramp_n == '0) ? ST_MUTED : ST_FADE_OUT;
                    end
                end
                ST_FADE_OUT: begin
                    if (mute_req) begin
                        ramp_n  = ramp_q - 1'b1;
                        state_n = (ramp_n == '0) ? ST_MUTED : ST_FADE_OUT;
                    end else begin
                        ramp_n  = ramp_q + 1'b1;
                        state_n = (ramp_n == FULL) ? ST_RUN : ST_FADE_IN;
                    end
                end
                ST_MUTED: begin
                    if (!mute_req) begin
                        ramp_n  = ramp_q + 1'b1;
                        state_n = (ramp_n == FULL) ? ST_RUN : ST_FADE_IN;
                    end
                end
                ST_FADE_IN: begin
                    if (mute_req) begin
                        ramp_n  = ramp_q - 1'b1;
                        state_n = (ramp_n == '0) ? ST_MUTED : ST_FADE_OUT;
                    end else begin
                        ramp_n  = ramp_q + 1'b1;
                        state_n = (ramp_n == FULL) ? ST_RUN : ST_FADE_IN;
                    end
                end
                default: begin
                    state_n = ST_RUN;
                    ramp_n  = FULL;
                end
            endcase
        end
    end

    assign ramp_lvl   = ramp_q;
    assign mute_state = state_q;

endmodule

// File: rtl/sg_scale_chan.sv
module sg_scale_chan #(
    parameter int DATA_W = 20,
    parameter int GAIN_W = 17,
    parameter int FRAC   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] smp,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [DATA_W-1:0] y
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((longint'(1) << (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - 1;
    localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(longint'(1) << (FRAC - 1));

    logic signed [PROD_W-1:0] prod, rnd, shifted, clamped;

    always_comb begin
        prod    = PROD_W'(smp) * PROD_W'($signed({1'b0, gain}));
        rnd     = prod + HALF;
        shifted = rnd >>> FRAC;
        if (shifted > SAT_HI)      clamped = SAT_HI;
        else if (shifted < SAT_LO) clamped = SAT_LO;
        else                       clamped = shifted;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  y <= '0;
        else if (en) y <= clamped[DATA_W-1:0];
    end

endmodule

// File: rtl/stereo_gain_stage.sv
module stereo_gain_stage #(
    parameter int DATA_W       = 20,
    parameter int CODE_W       = 6,
    parameter int MAX_ATTEN_DB = 60,
    parameter int RAMP_LEN     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic [CODE_W-1:0] vol_code,
    input  logic              mute_req,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    localparam int GAIN_W  = sg_pkg::GAIN_FRAC + 1;
    localparam int RAMP_W  = $clog2(RAMP_LEN + 1);
    localparam int RAMP_SH = $clog2(RAMP_LEN);
    localparam int N_CH    = 2;

    logic [GAIN_W-1:0]        vol_gain;
    logic [RAMP_W-1:0]        ramp_lvl;
    sg_pkg::mute_state_e      mute_state;
    logic [GAIN_W+RAMP_W-1:0] gain_prod;
    logic [GAIN_W-1:0]        eff_gain;

    logic                     s1_valid;
    logic [GAIN_W-1:0]        s1_gain;
    logic signed [DATA_W-1:0] s1_smp [N_CH];
    logic signed [DATA_W-1:0] y_smp  [N_CH];

    sg_gain_rom #(
        .CODE_W       (CODE_W),
        .MAX_ATTEN_DB (MAX_ATTEN_DB),
        .GAIN_W       (GAIN_W)
    ) rom_i (
        .code (vol_code),
        .gain (vol_gain)
    );

    sg_ramp_fsm #(
        .RAMP_LEN (RAMP_LEN)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (in_valid),
        .mute_req   (mute_req),
        .ramp_lvl   (ramp_lvl),
        .mute_state (mute_state)
    );

    // volume gain scaled by the soft-mute ramp (ramp is a power-of-two fraction)
    assign gain_prod = {{RAMP_W{1'b0}}, vol_gain} * {{GAIN_W{1'b0}}, ramp_lvl};
    assign eff_gain  = gain_prod[RAMP_SH +: GAIN_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_gain   <= '0;
            s1_smp[0] <= '0;
            s1_smp[1] <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_gain   <= eff_gain;
                s1_smp[0] <= $signed(in_left);
                s1_smp[1] <= $signed(in_right);
            end
        end
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        sg_scale_chan #(
            .DATA_W (DATA_W),
            .GAIN_W (GAIN_W),
            .FRAC   (sg_pkg::GAIN_FRAC)
        ) scale_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (s1_valid),
            .smp   (s1_smp[ch]),
            .gain  (s1_gain),
            .y     (y_smp[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_valid;
    end

    assign out_left  = y_smp[0];
    assign out_right = y_smp[1];

endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
    parameter int DATA_W   = 20,
    parameter int GAIN_W   = 17,
    parameter int RAMP_LEN = 32,
    localparam int RAMP_W  = $clog2(RAMP_LEN + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                s1_valid,
    input logic [GAIN_W-1:0]   s1_gain,
    input logic                out_valid,
    input logic [DATA_W-1:0]   out_left,
    input logic [DATA_W-1:0]   out_right,
    input logic [RAMP_W-1:0]   ramp_lvl,
    input sg_pkg::mute_state_e mute_state
);
    import sg_pkg::*;

    localparam logic [RAMP_W-1:0] FULL = RAMP_W'(RAMP_LEN);

    logic hist1, hist2;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist1 <= 1'b0;
            hist2 <= 1'b0;
        end else begin
            hist1 <= 1'b1;
            hist2 <= hist1;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hist2 |-> (out_valid == $past(in_valid, 2)));

    assert_ramp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_lvl <= FULL);

    assert_ramp_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hist1 && !$past(in_valid)) |-> $stable(ramp_lvl));

    assert_ramp_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hist1 |-> ((ramp_lvl == $past(ramp_lvl)) ||
                   (ramp_lvl == $past(ramp_lvl) + 1'b1) ||
                   (ramp_lvl + 1'b1 == $past(ramp_lvl))));

    assert_muted_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_state == ST_MUTED) |-> (ramp_lvl == '0));

    assert_run_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_state == ST_RUN) |-> (ramp_lvl == FULL));

    assert_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_gain == '0) |=> (out_left == '0 && out_right == '0));

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hist1 && !out_valid) |-> ($stable(out_left) && $stable(out_right)));

endmodule

bind stereo_gain_stage sg_checker #(
    .DATA_W   (DATA_W),
    .GAIN_W   (GAIN_W),
    .RAMP_LEN (RAMP_LEN)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .s1_valid   (s1_valid),
    .s1_gain    (s1_gain),
    .out_valid  (out_valid),
    .out_left   (out_left),
    .out_right  (out_right),
    .ramp_lvl   (ramp_lvl),
    .mute_state (mute_state)
);

// File: tb/stereo_gain_stage_tb.sv
`timescale 1ns/1ps
module stereo_gain_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_left = '0;
    logic [19:0] in_right = '0;
    logic [5:0]  vol_code = '0;
    logic        mute_req = 1'b0;
    logic        out_valid;
    logic [19:0] out_left;
    logic [19:0] out_right;

    int n_checks = 0;
    int n_fails  = 0;
    int mdl_ramp = 32;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    stereo_gain_stage dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .vol_code  (vol_code),
        .mute_req  (mute_req),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    // gain table from the recurrence stated in R4, zero for R5 codes
    function automatic longint ref_gain(input int code);
        int steps;
        longint g;
        steps = (code <= 1) ? 0 : code - 1;
        if (steps > 60) return 0;
        g = 65536;
        for (int i = 0; i < steps; i++) g = (g * 58409 + 32768) >> 16;
        return g;
    endfunction

    // R6/R7 expected output for one channel
    function automatic int ref_out(input int x, input int code, input int r);
        longint geff, p;
        geff = (ref_gain(code) * r) >> 5;
        p = (longint'(x) * geff + 32768) >>> 16;
        if (p > 524287)  p = 524287;
        if (p < -524288) p = -524288;
        return int'(p);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_sample(input int l, input int r, input int code,
                              input bit mute, input string req);
        int el, er;
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = 20'(l);
        in_right = 20'(r);
        vol_code = 6'(code);
        mute_req = mute;
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(posedge clk); #1;
        el = ref_out(l, code, mdl_ramp);
        er = ref_out(r, code, mdl_ramp);
        check("R2 out_valid pulse", out_valid, 1);
        check({req, " left"},  $signed(out_left),  el);
        check({req, " right"}, $signed(out_right), er);
        if (mute) mdl_ramp = (mdl_ramp > 0)  ? mdl_ramp - 1 : 0;
        else      mdl_ramp = (mdl_ramp < 32) ? mdl_ramp + 1 : 32;
        @(posedge clk); #1;
        check("R2 out_valid single", out_valid, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int hold_l;
        void'($urandom(32'h1C0FFEE));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 out_left",  out_left, 0);
        check("R1 out_right", out_right, 0);
        // R1: first unmuted sample at unity proves ramp full after reset
        run_sample(12345, -54321, 0, 1'b0, "R1 ramp full");

        // R3 unity codes, bit exact at extremes
        run_sample(524287, -524288, 0, 1'b0, "R3 code0");
        run_sample(-524288, 524287, 1, 1'b0, "R3 code1");
        run_sample(1, -1, 1, 1'b0, "R3 small");

        // R4 attenuation steps
        run_sample(262144, -262144, 2, 1'b0, "R4 code2");
        run_sample(524287, -300000, 21, 1'b0, "R4 code21");
        run_sample(524287, -524288, 61, 1'b0, "R4 code61");

        // R5 silence codes
        run_sample(524287, -524288, 62, 1'b0, "R5 code62");
        run_sample(400000, -1234, 63, 1'b0, "R5 code63");

        // R6 rounding near half LSB
        run_sample(1, -1, 2, 1'b0, "R6 round");
        run_sample(3, -3, 7, 1'b0, "R6 round");

        // R9 equal inputs give equal outputs
        run_sample(333333, 333333, 13, 1'b0, "R9 same gain");
        check("R9 left==right", out_left, out_right);

        // R7/R10 fade out fully, dwell muted, fade in
        for (int i = 0; i < 36; i++) run_sample(500000, -500000, 0, 1'b1, "R7 fade out");
        check("R10 muted output zero", out_left, 0);
        for (int i = 0; i < 10; i++) run_sample(500000, -500000, 4, 1'b0, "R7 fade in");
        for (int i = 0; i < 5; i++)  run_sample(500000, -500000, 4, 1'b1, "R10 reverse");
        for (int i = 0; i < 40; i++) run_sample(500000, -500000, 4, 1'b0, "R10 back to run");

        // R8: control changes without a strobe are ignored
        run_sample(100000, -100000, 10, 1'b1, "R8 setup");
        hold_l = $signed(out_left);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            vol_code = 6'($urandom_range(0, 63));
            mute_req = ~mute_req;
        end
        @(posedge clk); #1;
        check("R8 held output", $signed(out_left), hold_l);
        run_sample(100000, -100000, 10, 1'b0, "R8 ramp untouched");

        // seeded random traffic
        for (int i = 0; i < 400; i++) begin
            int code, l, r;
            bit m;
            code = $urandom_range(0, 63);
            l = int'($urandom_range(0, 1048575)) - 524288;
            r = int'($urandom_range(0, 1048575)) - 524288;
            m = ($urandom_range(0, 9) < 3);
            run_sample(l, r, code, m, "R6 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule